// File: doc/BRIEF.md
# Synchronizable PWM Time-Base Counter

This block is the timing heart of one PWM channel. A counter, 16 bits wide by default, advances once per time-base tick. The tick is a single-cycle enable that a prescaler derives from the system clock. The counter can run in four ways: counting up with a wrap to zero, counting down with a reload of the period, counting up and then down in a triangle, or holding its value. It reports when it sits at zero or at the period value, which way it last moved, and, through a sticky flag, that it has reached its all-ones value.

Several instances are chained so that they share one time base. Each instance takes a sync pulse from the instance before it. Software can also issue a sync strobe. Either source can load a phase offset into the counter, so one channel leads or lags another by a fixed amount. Each instance also drives a sync pulse to the next instance, and software chooses what produces that pulse. A shared run input holds every instance stopped and cleared until it rises, so that all instances start on the same clock edge. The period register can be double-buffered, so that a new period only takes effect at a count boundary. Software programs the block through a plain write port with four addresses.

Top module: `pwm_timebase`

## Requirements
- R1: With mode field ctrl[1:0]=0 (up), the counter advances by one per tick and, on a tick when it is at or above the active period, goes to 0 on the next tick instead. For period P the sequence is 0,1,…,P,0.
- R2: With mode 1 (down), the counter decreases by one per tick and, on a tick when it is at 0, reloads the active period. From reset the sequence is 0,P,P-1,…,0.
- R3: With mode 2 (up-down), the counter climbs from 0 to P and then falls back to 0, giving a repeat of 2P ticks. The output dir_up is 1 after a rising step and 0 after a falling step.
- R4: With mode 3 (hold), the counter keeps its value on every tick.
- R5: The prescale field ctrl[9:7]=s gives one tick every 2^s system clocks. The first tick comes 2^s clocks after run rises.
- R6: While run is low, the counter is 0, dir_up is 1 and the prescaler is cleared. Reset gives the same state and a cleared flag.
- R7: With ctrl[3]=0, a write to address 1 goes to a shadow period. The shadow is copied to the active period on a tick that finds the counter at 0, and the count step on that same tick still uses the old period.
- R8: With ctrl[3]=1, a write to address 1 changes the active period at once.
- R9: Address 2 holds the phase value. With phase load enabled (ctrl[2]=1), a sync event loads the phase value into the counter at the next tick. A sync event is either a sync_in pulse or a write to address 0 with bit 10 set. An event that arrives between ticks is held until the next tick.
- R10: With ctrl[2]=0, a sync event leaves the count unchanged.
- R11: In up-down mode, a phase load sets dir_up to ctrl[4], whatever the direction was before the load.
- R12: The field ctrl[6:5] selects what drives sync_out. The codes are: 0 the sync event passed through, 1 the counter at zero, 2 the cmpb_hit input, 3 a constant 0.
- R13: max_flag is set after the counter holds all ones. It stays set until a write to address 3 with bit 0 set clears it.
- R14: evt_zero is high while the counter is 0, and evt_period is high while the counter equals the active period. Both are low while run is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Global start; low holds prescaler and counter cleared |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 control, 1 period, 2 phase, 3 flag clear |
| wr_data | input | CNT_W | Write data |
| sync_in | input | 1 | Sync pulse from the previous module in the chain |
| cmpb_hit | input | 1 | Compare-B match from the compare unit |
| cnt | output | CNT_W | Current counter value |
| dir_up | output | 1 | Counting direction, 1 = rising |
| evt_zero | output | 1 | Counter equals zero |
| evt_period | output | 1 | Counter equals active period |
| max_flag | output | 1 | Sticky all-ones flag |
| sync_out | output | 1 | Sync pulse to the next module in the chain |

## Verification
The checker tests several rules on every clock. In up mode the wrap to zero must happen. In down mode the reload must use the period active at that moment. Hold mode must keep the count, and the count must not move between ticks. A phase load must land on the next edge. A stopped counter must stay at zero, and the all-ones flag must be set. Some behaviour shows only across whole scenarios, so the bench covers it: the sequence lengths of each mode and period, the tick spacing for each prescale value, the deferred period load, a sync event held across a skipped tick, and the direction chosen after a load.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

   typedef enum logic [1:0] {
      CM_UP   = 2'd0,
      CM_DOWN = 2'd1,
      CM_UPDN = 2'd2,
      CM_HOLD = 2'd3
   } cnt_mode_e;

   typedef enum logic [1:0] {
      SO_PASS = 2'd0,
      SO_ZERO = 2'd1,
      SO_CMPB = 2'd2,
      SO_OFF  = 2'd3
   } sync_src_e;

   localparam int PS_FIELD_W = 3;
   localparam int CTRL_W     = 10;
   localparam int SWSYNC_BIT = 10;

   localparam int A_CTRL  = 0;
   localparam int A_PRD   = 1;
   localparam int A_PHASE = 2;
   localparam int A_FLAG  = 3;

   typedef struct packed {
      logic [PS_FIELD_W-1:0] ps_sel;       // [9:7]
      sync_src_e             so_sel;       // [6:5]
      logic                  dir_on_sync;  // [4]
      logic                  shadow_off;   // [3]
      logic                  phase_en;     // [2]
      cnt_mode_e             mode;         // [1:0]
   } ctrl_t;

endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
   parameter int SEL_W = 3,
   localparam int DIV_W = (1 << SEL_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] limit;

   always_comb limit = DIV_W'((32'd1 << sel) - 32'd1);

   assign tick = run && (div_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              div_q <= '0;
      else if (!run || tick)   div_q <= '0;
      else                     div_q <= div_q + DIV_W'(1);
   end

endmodule

// File: rtl/tbase_period.sv
module tbase_period #(
   parameter int            W          = 16,
   parameter bit            HAS_SHADOW = 1'b1,
   parameter logic [W-1:0]  RST_VAL    = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         direct,
   input  logic         load_zero,
   output logic [W-1:0] active
);

   generate
      if (HAS_SHADOW) begin : g_shadow
         logic [W-1:0] shadow_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow_q <= RST_VAL;
               active   <= RST_VAL;
            end else begin
               if (wr) shadow_q <= wdata;
               if (wr && direct)  active <= wdata;
               else if (load_zero) active <= shadow_q;
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  active <= RST_VAL;
            else if (wr) active <= wdata;
         end
      end
   endgenerate

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
   import tbase_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         tick,
   input  cnt_mode_e    mode,
   input  logic [W-1:0] prd,
   input  logic         ld_phase,
   input  logic [W-1:0] phase,
   input  logic         dir_on_sync,
   output logic [W-1:0] cnt,
   output logic         dir_up
);

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] nxt_cnt;
   logic         nxt_dir;

   always_comb begin
      nxt_cnt = cnt;
      nxt_dir = dir_up;
      if (ld_phase) begin
         nxt_cnt = phase;
         case (mode)
            CM_UPDN: nxt_dir = dir_on_sync;
            CM_DOWN: nxt_dir = 1'b0;
            default: nxt_dir = 1'b1;
         endcase
      end else begin
         case (mode)
            CM_UP: begin
               nxt_dir = 1'b1;
               nxt_cnt = (cnt >= prd) ? '0 : cnt + ONE;
            end
            CM_DOWN: begin
               nxt_dir = 1'b0;
               nxt_cnt = (cnt == '0) ? prd : cnt - ONE;
            end
            CM_UPDN: begin
               if (dir_up) begin
                  if (cnt >= prd) begin
                     nxt_dir = 1'b0;
                     nxt_cnt = (cnt == '0) ? '0 : cnt - ONE;
                  end else begin
                     nxt_cnt = cnt + ONE;
                  end
               end else begin
                  if (cnt == '0) begin
                     nxt_dir = 1'b1;
                     nxt_cnt = (prd == '0) ? '0 : ONE;
                  end else begin
                     nxt_cnt = cnt - ONE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         dir_up <= 1'b1;
      end else if (!run) begin
         cnt    <= '0;
         dir_up <= 1'b1;
      end else if (tick) begin
         cnt    <= nxt_cnt;
         dir_up <= nxt_dir;
      end
   end

endmodule

// File: rtl/tbase_syncsel.sv
module tbase_syncsel
   import tbase_pkg::*;
(
   input  sync_src_e sel,
   input  logic      sync_evt,
   input  logic      at_zero,
   input  logic      cmpb_hit,
   output logic      sync_out
);

   always_comb begin
      case (sel)
         SO_PASS: sync_out = sync_evt;
         SO_ZERO: sync_out = at_zero;
         SO_CMPB: sync_out = cmpb_hit;
         default: sync_out = 1'b0;
      endcase
   end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import tbase_pkg::*;
#(
   parameter int               CNT_W      = 16,
   parameter int               ADDR_W     = 2,
   parameter bit               HAS_SHADOW = 1'b1,
   parameter logic [CNT_W-1:0] PRD_RST    = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              sync_in,
   input  logic              cmpb_hit,
   output logic [CNT_W-1:0]  cnt,
   output logic              dir_up,
   output logic              evt_zero,
   output logic              evt_period,
   output logic              max_flag,
   output logic              sync_out
);

   generate
      if (CNT_W < SWSYNC_BIT + 1) begin : g_bad_width
         $error("pwm_timebase: CNT_W must hold the control word");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("pwm_timebase: ADDR_W must be at least 2");
      end
   endgenerate

   ctrl_t            ctrl_q;
   cnt_mode_e        mode_q;
   logic [CNT_W-1:0] phase_q;
   logic [CNT_W-1:0] prd_act;
   logic             pend_q;
   logic             tick;
   logic             wr_ctrl, wr_prd, wr_phase, wr_flag;
   logic             sw_sync, sync_evt, ld_phase, at_zero;

   assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(A_CTRL));
   assign wr_prd   = wr_en && (wr_addr == ADDR_W'(A_PRD));
   assign wr_phase = wr_en && (wr_addr == ADDR_W'(A_PHASE));
   assign wr_flag  = wr_en && (wr_addr == ADDR_W'(A_FLAG));

   assign sw_sync  = wr_ctrl && wr_data[SWSYNC_BIT];
   assign sync_evt = sync_in || sw_sync;
   assign ld_phase = tick && ctrl_q.phase_en && (pend_q || sync_evt);
   assign mode_q   = ctrl_q.mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         phase_q <= '0;
      end else begin
         if (wr_ctrl)  ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
         if (wr_phase) phase_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q <= 1'b0;
      else if (!run)     pend_q <= 1'b0;
      else if (tick)     pend_q <= 1'b0;
      else if (sync_evt) pend_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    max_flag <= 1'b0;
      else if (run && (&cnt))        max_flag <= 1'b1;
      else if (wr_flag && wr_data[0]) max_flag <= 1'b0;
   end

   tbase_prescaler #(.SEL_W(PS_FIELD_W)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .sel   (ctrl_q.ps_sel),
      .tick  (tick)
   );

   tbase_period #(.W(CNT_W), .HAS_SHADOW(HAS_SHADOW), .RST_VAL(PRD_RST)) u_prd (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_prd),
      .wdata     (wr_data),
      .direct    (ctrl_q.shadow_off),
      .load_zero (tick && (cnt == '0)),
      .active    (prd_act)
   );

   tbase_counter #(.W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .tick        (tick),
      .mode        (mode_q),
      .prd         (prd_act),
      .ld_phase    (ld_phase),
      .phase       (phase_q),
      .dir_on_sync (ctrl_q.dir_on_sync),
      .cnt         (cnt),
      .dir_up      (dir_up)
   );

   assign at_zero    = run && (cnt == '0);
   assign evt_zero   = at_zero;
   assign evt_period = run && (cnt == prd_act);

   tbase_syncsel u_sync (
      .sel      (ctrl_q.so_sel),
      .sync_evt (sync_evt),
      .at_zero  (at_zero),
      .cmpb_hit (cmpb_hit),
      .sync_out (sync_out)
   );

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
   import tbase_pkg::*;
#(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         run,
   input logic         tick,
   input logic         ld_phase,
   input cnt_mode_e    mode,
   input logic [W-1:0] cnt,
   input logic         dir_up,
   input logic [W-1:0] prd_act,
   input logic [W-1:0] phase,
   input logic         max_flag
);

   // R1
   up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !ld_phase && mode == CM_UP && cnt >= prd_act |=> cnt == '0);

   // R2
   down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !ld_phase && mode == CM_DOWN && cnt == '0 |=> cnt == $past(prd_act));

   // R4
   hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !ld_phase && mode == CM_HOLD |=> $stable(cnt));

   // R5
   no_tick_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && !tick |=> $stable(cnt));

   // R6
   stopped_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == '0 && dir_up);

   // R9
   phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_phase |=> cnt == $past(phase));

   // R13
   max_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && (&cnt) |=> max_flag);

endmodule

bind pwm_timebase pwm_timebase_chk #(.W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .tick     (tick),
   .ld_phase (ld_phase),
   .mode     (mode_q),
   .cnt      (cnt),
   .dir_up   (dir_up),
   .prd_act  (prd_act),
   .phase    (phase_q),
   .max_flag (max_flag)
);

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        sync_in = 1'b0;
   logic        cmpb_hit = 1'b0;
   logic [15:0] cnt;
   logic        dir_up, evt_zero, evt_period, max_flag, sync_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   pwm_timebase u_dut (
      .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sync_in(sync_in), .cmpb_hit(cmpb_hit), .cnt(cnt),
      .dir_up(dir_up), .evt_zero(evt_zero), .evt_period(evt_period),
      .max_flag(max_flag), .sync_out(sync_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ctl(input int mode, input int phen, input int shoff,
                              input int dirup, input int so, input int ps);
      return mode | (phen << 2) | (shoff << 3) | (dirup << 4) | (so << 5) | (ps << 7);
   endfunction

   task automatic tk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_sync();
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
   endtask

   // stop, configure with direct period, then start; returns at n = 0
   task automatic setup(input int c, input int p, input int ph);
      run = 1'b0;
      tk(1);
      wr(2, ph);
      wr(0, c | (1 << 3));
      wr(1, p);
      wr(0, c);
      run = 1'b1;
   endtask

   initial begin
      tk(3);
      chk(cnt == 0 && dir_up && !max_flag && !evt_zero, "R6 reset", int'(cnt), 0);
      rst_n = 1'b1;
      tk(2);

      // R1 up sweep, with R14 events
      for (int p = 0; p <= 6; p++) begin
         setup(ctl(0,0,1,0,3,0), p, 0);
         for (int n = 1; n <= 2*p + 4; n++) begin
            int e;
            tk(1);
            e = n % (p + 1);
            chk(int'(cnt) == e, "R1 up count", int'(cnt), e);
            chk(evt_zero == (e == 0) && evt_period == (e == p), "R14 events", int'(evt_period), int'(e == p));
         end
      end
      run = 1'b0; tk(1);
      chk(cnt == 0 && dir_up && !evt_zero, "R6 run low", int'(cnt), 0);

      // R2 down sweep
      for (int p = 1; p <= 6; p++) begin
         setup(ctl(1,0,1,0,3,0), p, 0);
         for (int n = 1; n <= 2*p + 4; n++) begin
            int e;
            tk(1);
            e = (p + 1 - (n % (p + 1))) % (p + 1);
            chk(int'(cnt) == e, "R2 down count", int'(cnt), e);
         end
      end

      // R3 up-down sweep
      for (int p = 1; p <= 6; p++) begin
         setup(ctl(2,0,1,0,3,0), p, 0);
         for (int n = 1; n <= 4*p + 2; n++) begin
            int t, e;
            bit d;
            tk(1);
            t = n % (2*p);
            e = (t <= p) ? t : 2*p - t;
            d = (t >= 1 && t <= p);
            chk(int'(cnt) == e, "R3 updown count", int'(cnt), e);
            chk(dir_up == d, "R3 direction", int'(dir_up), int'(d));
         end
      end

      // R5 prescaler sweep
      for (int s = 0; s <= 3; s++) begin
         setup(ctl(0,0,1,0,3,s), 3, 0);
         for (int n = 1; n <= 24; n++) begin
            int e;
            tk(1);
            e = (n >> s) % 4;
            chk(int'(cnt) == e, "R5 prescale", int'(cnt), e);
         end
      end

      // R4 hold mode
      setup(ctl(0,0,1,0,3,0), 10, 0);
      tk(3);
      wr(0, ctl(3,0,1,0,3,0));
      chk(cnt == 4, "R4 entry", int'(cnt), 4);
      tk(5);
      chk(cnt == 4, "R4 hold", int'(cnt), 4);

      // R7 shadowed period
      setup(ctl(0,0,0,0,3,0), 5, 0);
      tk(2);
      wr(1, 2);
      chk(cnt == 3, "R7 after write", int'(cnt), 3);
      tk(2);
      chk(cnt == 5, "R7 old period kept", int'(cnt), 5);
      tk(1);
      chk(cnt == 0, "R7 wrap", int'(cnt), 0);
      tk(2);
      chk(cnt == 2 && evt_period, "R7 new period", int'(cnt), 2);
      tk(1);
      chk(cnt == 0, "R7 new wrap", int'(cnt), 0);

      // R8 direct period
      setup(ctl(0,0,1,0,3,0), 5, 0);
      tk(2);
      wr(1, 3);
      chk(cnt == 3, "R8 step", int'(cnt), 3);
      tk(1);
      chk(cnt == 0, "R8 immediate wrap", int'(cnt), 0);

      // R9 sync load
      setup(ctl(0,1,1,0,3,0), 10, 7);
      tk(2);
      pulse_sync();
      chk(cnt == 7, "R9 sync load", int'(cnt), 7);
      tk(1);
      chk(cnt == 8, "R9 after load", int'(cnt), 8);

      // R9 event held across a skipped tick
      setup(ctl(0,1,1,0,3,1), 10, 7);
      tk(2);
      pulse_sync();
      chk(cnt == 1, "R9 held until tick", int'(cnt), 1);
      tk(1);
      chk(cnt == 7, "R9 pending load", int'(cnt), 7);

      // R9 software strobe
      setup(ctl(0,1,1,0,3,0), 10, 7);
      tk(3);
      wr(0, ctl(0,1,1,0,3,0) | (1 << 10));
      chk(cnt == 7, "R9 sw strobe", int'(cnt), 7);

      // R10 phase load off, R12 pass-through
      setup(ctl(0,0,1,0,0,0), 10, 7);
      tk(2);
      sync_in = 1'b1;
      #1;
      chk(sync_out == 1'b1, "R12 pass", int'(sync_out), 1);
      @(negedge clk);
      sync_in = 1'b0;
      chk(cnt == 3, "R10 ignored", int'(cnt), 3);

      // R11 direction after sync
      setup(ctl(2,1,1,0,3,0), 10, 7);
      tk(2);
      pulse_sync();
      chk(cnt == 7 && !dir_up, "R11 down after load", int'(dir_up), 0);
      tk(1);
      chk(cnt == 6, "R11 falling", int'(cnt), 6);
      setup(ctl(2,1,1,1,3,0), 10, 7);
      tk(2);
      pulse_sync();
      chk(cnt == 7 && dir_up, "R11 up after load", int'(dir_up), 1);
      tk(1);
      chk(cnt == 8, "R11 rising", int'(cnt), 8);

      // R12 sync output sources
      setup(ctl(0,0,1,0,1,0), 3, 0);
      #1;
      chk(sync_out == 1'b1, "R12 zero src", int'(sync_out), 1);
      tk(1);
      chk(sync_out == 1'b0, "R12 zero src off", int'(sync_out), 0);
      wr(0, ctl(0,0,1,0,2,0));
      cmpb_hit = 1'b1; #1;
      chk(sync_out == 1'b1, "R12 cmpb src", int'(sync_out), 1);
      cmpb_hit = 1'b0; #1;
      chk(sync_out == 1'b0, "R12 cmpb low", int'(sync_out), 0);
      @(negedge clk);
      wr(0, ctl(0,0,1,0,3,0));
      sync_in = 1'b1; #1;
      chk(sync_out == 1'b0, "R12 disabled", int'(sync_out), 0);
      @(negedge clk);
      sync_in = 1'b0;

      // R13 sticky max flag
      setup(ctl(0,1,1,0,3,0), 10, 16'hFFFF);
      tk(1);
      pulse_sync();
      chk(cnt == 16'hFFFF && !max_flag, "R13 at max", int'(max_flag), 0);
      tk(1);
      chk(max_flag, "R13 set", int'(max_flag), 1);
      tk(3);
      chk(max_flag, "R13 sticky", int'(max_flag), 1);
      wr(3, 1);
      chk(!max_flag, "R13 clear", int'(max_flag), 0);

      run = 1'b0;
      tk(2);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule